// File: doc/BRIEF.md
# Multi-lane serial voice sample receiver

This block collects 16-bit voice samples from several serial PCM links. On each link it acts as the slave side. An external master drives the bit clock and a frame marker, and the block never generates either one. The three line signals of every lane (bit clock, frame marker, serial data) are brought into the fast system clock by flop chains. The falling edges of the bit clock are found in the system clock domain. Every lane does this on its own, so each lane can follow a master whose clock is unrelated to the other lanes.

A frame starts with a marker that is high for one bit period. In the next bit period the line carries the most significant bit of the sample, and fifteen more bits follow. Bits after the sixteenth are ignored until the next marker. The master launches data on the rising edge of the bit clock, so the block samples on the falling edge.

Each finished sample waits in a one-deep holding slot for its lane. A round-robin picker presents one waiting lane at a time on a shared valid/ready output, together with the lane number. If a sample is still waiting when the next one from the same lane completes, the newer sample replaces it and a sticky overrun bit for that lane is set. The intended line rate is a 2.048 MHz bit clock with 8 kHz frames, which gives 256 bit periods per frame. The receiver does not depend on the frame length. The system clock must run at least 8 times faster than any bit clock.

Top module: `pcm_quad_rx`

## Requirements
- R1: After reset, `out_valid_o` is 0 and every bit of `overrun_o` is 0.
- R2: A lane's sample is made of the data bits taken at the 16 bit-clock falling edges that follow the falling edge at which the frame marker was seen high. The first bit taken is placed in bit 15 of `out_data_o` and the last one in bit 0.
- R3: Data bits on a lane that has seen no marker, and bits after the 16th of a frame, produce no output.
- R4: Each lane recovers its samples correctly and in order, even when the lanes run at different, unrelated bit-clock rates.
- R5: When a marker is seen high partway through a sample, the partial bits are discarded and a new 16-bit sample starts with the next bit.
- R6: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` stays 1 and `out_lane_o` stays unchanged. A sample leaves its lane only on a cycle where both are 1.
- R7: When a lane completes a sample while its previous sample is still waiting and is not taken in that cycle, the newer sample replaces the older one and `overrun_o` bit for that lane goes to 1. The bit stays 1 until reset.
- R8: When several lanes are waiting, lanes are served in rotating order. The lane served after lane k is the first waiting lane in the order k+1, k+2, … modulo 4, and the rotation starts at lane 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the fastest bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 4 | Bit clock of each lane, from the external master |
| fs_i | input | 4 | One-bit-period frame marker of each lane |
| dat_i | input | 4 | Serial data of each lane, most significant bit first |
| out_ready_i | input | 1 | Consumer accepts the presented sample |
| out_valid_o | output | 1 | A sample is presented |
| out_lane_o | output | 2 | Lane number of the presented sample |
| out_data_o | output | 16 | Presented sample |
| overrun_o | output | 4 | Sticky per-lane overrun flags |

## Verification
The in-line assertions check the output handshake on every cycle. They cover that a stalled output keeps its lane, that a lane's slot empties only on a grant with ready, and that the overrun flags never clear. They also check that the picker grants at most one lane and only a lane that is waiting. The bench has to show the serial decoding itself: bit order, alignment to the marker, discard on a restarted frame, the replacement value after an overrun, and the exact rotation order. It drives four lanes at different rates with random sample values, random gaps and aborted frames, while the consumer stalls at random.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    localparam int unsigned PCM_LANES_DEF  = 4;
    localparam int unsigned PCM_WORD_DEF   = 16;
    localparam int unsigned PCM_SYNC_DEF   = 2;

    // Deserialiser phase: waiting for a frame marker, or collecting bits
    typedef enum logic {
        RX_WAIT  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_phase_e;

endpackage

// File: rtl/pcm_line_sync.sv
module pcm_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fs_i,
    input  logic dat_i,
    output logic fall_o,
    output logic fs_o,
    output logic dat_o
);

    typedef struct packed {
        logic [STAGES-1:0] bclk_sh;
        logic [STAGES-1:0] fs_sh;
        logic [STAGES-1:0] dat_sh;
        logic              bclk_last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.bclk_sh   = {st_q.bclk_sh[STAGES-2:0], bclk_i};
        st_d.fs_sh     = {st_q.fs_sh[STAGES-2:0], fs_i};
        st_d.dat_sh    = {st_q.dat_sh[STAGES-2:0], dat_i};
        st_d.bclk_last = st_q.bclk_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Falling edge of the resynchronised bit clock; marker and data taken
    // from the same chain depth so all three see the same input instant.
    assign fall_o = st_q.bclk_last & ~st_q.bclk_sh[STAGES-1];
    assign fs_o   = st_q.fs_sh[STAGES-1];
    assign dat_o  = st_q.dat_sh[STAGES-1];

endmodule

// File: rtl/pcm_lane_rx.sv
module pcm_lane_rx
    import pcm_rx_pkg::*;
#(
    parameter int unsigned WORD_W = PCM_WORD_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              fs_i,
    input  logic              dat_i,
    input  logic              take_i,
    output logic              pend_o,
    output logic [WORD_W-1:0] word_o,
    output logic              ovr_o
);

    localparam int unsigned      CNT_W    = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        rx_phase_e         phase;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] hold;
        logic              pend;
        logic              ovr;
    } lane_t;

    lane_t ln_d, ln_q;
    logic  done;
    logic  [WORD_W-1:0] done_word;

    always_comb begin
        ln_d      = ln_q;
        done      = 1'b0;
        done_word = {ln_q.shreg[WORD_W-2:0], dat_i};

        if (fall_i) begin
            if (fs_i) begin
                // Marker seen: (re)start, any partial bits are dropped
                ln_d.phase = RX_SHIFT;
                ln_d.cnt   = '0;
            end else if (ln_q.phase == RX_SHIFT) begin
                ln_d.shreg = done_word;
                if (ln_q.cnt == LAST_BIT) begin
                    done       = 1'b1;
                    ln_d.phase = RX_WAIT;
                    ln_d.cnt   = '0;
                end else begin
                    ln_d.cnt = ln_q.cnt + 1'b1;
                end
            end
        end

        if (take_i) begin
            ln_d.pend = 1'b0;
        end
        if (done) begin
            ln_d.hold = done_word;
            ln_d.pend = 1'b1;
            if (ln_q.pend && !take_i) begin
                ln_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '{phase: RX_WAIT, default: '0};
        end else begin
            ln_q <= ln_d;
        end
    end

    assign pend_o = ln_q.pend;
    assign word_o = ln_q.hold;
    assign ovr_o  = ln_q.ovr;

    // R7: overrun flag is sticky
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ln_q.ovr |=> ln_q.ovr);

    // R6: a waiting sample only leaves through a grant
    p_pend_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_q.pend && !take_i) |=> ln_q.pend);

    // R6: the output side never takes from an empty slot
    p_take_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> ln_q.pend);

endmodule

// File: rtl/pcm_rr_pick.sv
module pcm_rr_pick #(
    parameter int unsigned LANES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  req_i,
    input  logic              adv_i,
    output logic [LANES-1:0]  gnt_o,
    output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] idx_o,
    output logic              any_o
);

    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic [LANE_W-1:0] ptr;
        logic              lock;
        logic [LANE_W-1:0] lock_idx;
    } rr_t;

    rr_t rr_d, rr_q;
    logic              found;
    logic [LANE_W-1:0] idx;
    int unsigned       cand;

    always_comb begin
        rr_d  = rr_q;
        found = 1'b0;
        idx   = '0;
        cand  = 0;
        for (int unsigned k = 0; k < LANES; k++) begin
            cand = int'(rr_q.ptr) + k;
            if (cand >= LANES) begin
                cand = cand - LANES;
            end
            if (!found && req_i[cand]) begin
                found = 1'b1;
                idx   = LANE_W'(cand);
            end
        end
        // A stalled presentation keeps its lane
        if (rr_q.lock && req_i[rr_q.lock_idx]) begin
            found = 1'b1;
            idx   = rr_q.lock_idx;
        end

        gnt_o = '0;
        if (found) begin
            gnt_o[idx] = 1'b1;
        end

        rr_d.lock     = found && !adv_i;
        rr_d.lock_idx = idx;
        if (found && adv_i) begin
            rr_d.ptr = (int'(idx) == LANES - 1) ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else begin
            rr_q <= rr_d;
        end
    end

    assign idx_o = idx;
    assign any_o = found;

    // R8: at most one lane granted
    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R8: a grant only goes to a waiting lane, and some lane is granted when any waits
    p_grant_in_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o & ~req_i) == '0) && ((req_i != '0) == (gnt_o != '0)));

endmodule

// File: rtl/pcm_quad_rx.sv
module pcm_quad_rx
    import pcm_rx_pkg::*;
#(
    parameter int unsigned LANES  = PCM_LANES_DEF,
    parameter int unsigned WORD_W = PCM_WORD_DEF,
    parameter int unsigned STAGES = PCM_SYNC_DEF,
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  bclk_i,
    input  logic [LANES-1:0]  fs_i,
    input  logic [LANES-1:0]  dat_i,
    input  logic              out_ready_i,
    output logic              out_valid_o,
    output logic [LANE_W-1:0] out_lane_o,
    output logic [WORD_W-1:0] out_data_o,
    output logic [LANES-1:0]  overrun_o
);

    logic [LANES-1:0]  fall_s, fs_s, dat_s;
    logic [LANES-1:0]  pend, gnt, take;
    logic [WORD_W-1:0] word [LANES];
    logic [LANE_W-1:0] pick_idx;
    logic              pick_any;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pcm_line_sync #(
            .STAGES (STAGES)
        ) sync_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .bclk_i (bclk_i[g]),
            .fs_i   (fs_i[g]),
            .dat_i  (dat_i[g]),
            .fall_o (fall_s[g]),
            .fs_o   (fs_s[g]),
            .dat_o  (dat_s[g])
        );

        pcm_lane_rx #(
            .WORD_W (WORD_W)
        ) rx_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .fall_i (fall_s[g]),
            .fs_i   (fs_s[g]),
            .dat_i  (dat_s[g]),
            .take_i (take[g]),
            .pend_o (pend[g]),
            .word_o (word[g]),
            .ovr_o  (overrun_o[g])
        );

        assign take[g] = gnt[g] & out_ready_i;
    end

    pcm_rr_pick #(
        .LANES (LANES)
    ) pick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (pend),
        .adv_i (out_ready_i),
        .gnt_o (gnt),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    assign out_valid_o = pick_any;
    assign out_lane_o  = pick_idx;
    assign out_data_o  = word[pick_idx];

    // R6: a stalled output keeps its valid and its lane
    p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_lane_o)));

    // R6: the presented lane really has a waiting sample
    p_lane_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> pend[out_lane_o]);

endmodule

// File: tb/pcm_quad_rx_tb_top.sv
module pcm_quad_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bclk = '0;
    logic [3:0]  fs = '0;
    logic [3:0]  dat = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [1:0]  out_lane;
    logic [15:0] out_data;
    logic [3:0]  overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_quad_rx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_i      (bclk),
        .fs_i        (fs),
        .dat_i       (dat),
        .out_ready_i (out_ready),
        .out_valid_o (out_valid),
        .out_lane_o  (out_lane),
        .out_data_o  (out_data),
        .overrun_o   (overrun)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected samples per lane, in order
    logic [15:0] exp_mem [NL][256];
    int          wr_p [NL];
    int          rd_p [NL];
    bit          mon_cmp = 0;
    int          last_lane = NL - 1;
    logic [1:0]  log_lane [64];
    logic [15:0] log_data [64];
    int          log_n = 0;

    initial begin
        for (int l = 0; l < NL; l++) begin
            wr_p[l] = 0;
            rd_p[l] = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            last_lane = int'(out_lane);
            if (log_n < 64) begin
                log_lane[log_n] = out_lane;
                log_data[log_n] = out_data;
            end
            log_n++;
            if (mon_cmp) begin
                if (rd_p[out_lane] < wr_p[out_lane]) begin
                    chk(out_data == exp_mem[out_lane][rd_p[out_lane] % 256],
                        "R2 R4 sample value", {16'h0, out_data},
                        {16'h0, exp_mem[out_lane][rd_p[out_lane] % 256]});
                    rd_p[out_lane]++;
                end else begin
                    chk(1'b0, "R3 unexpected sample", {16'h0, out_data}, 32'h0);
                end
            end
        end
    end

    function automatic logic rbit();
        return ($urandom % 2) == 1;
    endfunction

    task automatic set_ready(input logic v);
        @(posedge clk);
        #1 out_ready = v;
    endtask

    // One bit period: data launched at the rising edge
    task automatic send_bit(input int l, input int half, input logic f, input logic d);
        @(negedge clk);
        bclk[l] = 1'b1;
        fs[l]   = f;
        dat[l]  = d;
        repeat (half) @(negedge clk);
        bclk[l] = 1'b0;
        repeat (half - 1) @(negedge clk);
    endtask

    task automatic send_frame(input int l, input int half, input logic [15:0] val,
                              input int partial, input int pad, input bit push);
        if (push) begin
            exp_mem[l][wr_p[l] % 256] = val;
            wr_p[l]++;
        end
        if (partial > 0) begin
            send_bit(l, half, 1'b1, rbit());
            repeat (partial) send_bit(l, half, 1'b0, rbit());
        end
        send_bit(l, half, 1'b1, rbit());
        for (int b = 15; b >= 0; b--) begin
            send_bit(l, half, 1'b0, val[b]);
        end
        repeat (pad) send_bit(l, half, 1'b0, rbit());
    endtask

    task automatic lane_run(input int l, input int nfr);
        for (int i = 0; i < nfr; i++) begin
            logic [15:0] v;
            int part;
            v    = 16'($urandom);
            part = (($urandom % 4) == 0) ? int'(1 + $urandom % 14) : 0;
            send_frame(l, 5 + 2 * l, v, part, int'(1 + $urandom % 6), 1'b1);
        end
    endtask

    bit rdy_run;
    int base;
    int lsave;

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 valid after reset", {31'h0, out_valid}, 32'h0);
        chk(overrun == 4'h0, "R1 overrun after reset", {28'h0, overrun}, 32'h0);

        // R3: no marker, no output
        mon_cmp = 1;
        set_ready(1'b1);
        base = log_n;
        repeat (40) send_bit(2, 5, 1'b0, rbit());
        repeat (20) @(negedge clk);
        chk(log_n == base, "R3 bits without marker", log_n, base);
        chk(out_valid == 1'b0, "R3 no valid without marker", {31'h0, out_valid}, 32'h0);

        // R2 R4 R5: random traffic on all lanes, random stalls
        rdy_run = 1;
        fork
            begin
                fork
                    lane_run(0, 12);
                    lane_run(1, 12);
                    lane_run(2, 12);
                    lane_run(3, 12);
                join
                repeat (40) @(negedge clk);
                rdy_run = 0;
            end
            begin
                while (rdy_run) begin
                    @(posedge clk);
                    #1 out_ready = ($urandom % 4) != 0;
                end
            end
        join
        set_ready(1'b1);
        repeat (20) @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            chk(rd_p[l] == wr_p[l], "R4 all lane samples delivered", rd_p[l], wr_p[l]);
        end
        chk(overrun == 4'h0, "R7 no overrun under light stalls", {28'h0, overrun}, 32'h0);

        // R5: marker in mid-sample restarts the word
        base = log_n;
        send_frame(1, 6, 16'hA5C3, 9, 2, 1'b1);
        repeat (20) @(negedge clk);
        chk(log_n == base + 1, "R5 one sample after restart", log_n, base + 1);
        chk(rd_p[1] == wr_p[1], "R5 restarted word delivered", rd_p[1], wr_p[1]);

        // R7 R6: overrun replaces the waiting sample
        mon_cmp = 0;
        set_ready(1'b0);
        send_frame(0, 5, 16'h1111, 0, 2, 1'b0);
        repeat (10) @(negedge clk);
        chk(out_valid && out_lane == 2'd0 && out_data == 16'h1111, "R6 first sample presented",
            {out_valid, 13'h0, out_lane, out_data}, {1'b1, 15'h0, 16'h1111});
        chk(overrun == 4'h0, "R7 no overrun yet", {28'h0, overrun}, 32'h0);
        send_frame(0, 5, 16'h2222, 0, 2, 1'b0);
        repeat (10) @(negedge clk);
        chk(overrun == 4'b0001, "R7 overrun flag lane 0", {28'h0, overrun}, 32'h1);
        chk(out_valid && out_lane == 2'd0 && out_data == 16'h2222, "R7 newer sample kept",
            {out_valid, 13'h0, out_lane, out_data}, {1'b1, 15'h0, 16'h2222});
        base = log_n;
        set_ready(1'b1);
        set_ready(1'b0);
        repeat (3) @(negedge clk);
        chk(log_n == base + 1, "R6 exactly one transfer", log_n, base + 1);
        chk(log_data[base % 64] == 16'h2222, "R7 transferred value", {16'h0, log_data[base % 64]}, 32'h2222);
        chk(out_valid == 1'b0, "R6 slot empty after transfer", {31'h0, out_valid}, 32'h0);

        // R8: all four lanes complete together, then drain
        fork
            send_frame(0, 6, 16'hC000, 0, 1, 1'b0);
            send_frame(1, 6, 16'hC001, 0, 1, 1'b0);
            send_frame(2, 6, 16'hC002, 0, 1, 1'b0);
            send_frame(3, 6, 16'hC003, 0, 1, 1'b0);
        join
        repeat (10) @(negedge clk);
        lsave = int'(out_lane);
        repeat (5) @(negedge clk);
        chk(int'(out_lane) == lsave && out_valid, "R6 lane held during stall", out_lane, lsave);
        lsave = last_lane;
        base = log_n;
        set_ready(1'b1);
        repeat (6) @(negedge clk);
        set_ready(1'b0);
        chk(log_n == base + 4, "R8 four transfers", log_n, base + 4);
        for (int k = 0; k < 4; k++) begin
            int el;
            el = (lsave + 1 + k) % NL;
            chk(int'(log_lane[(base + k) % 64]) == el, "R8 rotation order", log_lane[(base + k) % 64], el);
            chk(log_data[(base + k) % 64] == (16'hC000 + 16'(el)), "R8 data of lane",
                log_data[(base + k) % 64], 16'hC000 + 16'(el));
        end
        chk(overrun == 4'b0001, "R7 flag still set", {28'h0, overrun}, 32'h1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule